// File: doc/BRIEF.md
# VLIW Bundle Length Framer

The framer sits behind an instruction fetch path and accepts one byte per cycle on a valid/ready stream. It cuts the stream into instruction or bundle frames and presents one frame descriptor at a time. Each descriptor carries the byte offset of the frame from the start of the stream, its length in bytes, and a flag that marks a leading byte with no legal length. Opcode and operand decode inside a frame belongs to later stages.

The length is found in two levels. A 256-entry class table, indexed by the leading byte, gives one of six class codes: illegal, 2, 3, 8 or 16 bytes, or an escape. An escape is settled by a bit of the frame's fourth byte (index 3), which picks 8 or 16 bytes. The frame advance logic then handles only the real frame sizes 2, 3, 8 and 16, plus a one-byte resync step after an illegal leading byte. A mode input replaces the table with a fixed rule for a narrow scalar core. The table can be rewritten at run time through a write port while nothing is buffered.

A 32-byte window, equal to the widest fetch, holds the bytes that have arrived. A descriptor is shown only once the whole frame is in the window. It holds steady until it is taken.

Top module: `bundle_framer`

## Requirements
- R1: After reset `frm_valid_o` is 0, `in_ready_o` is 1 and the first frame's offset is 0.
- R2: After reset the table maps leading bytes as follows: 0x00-0x5F give 2 bytes, 0x60-0xDF give 3 bytes, 0xE0-0xE7 give 8 bytes, 0xF8 is the escape, the other bytes in 0xE8-0xFD give 16 bytes, and 0xFE-0xFF are illegal.
- R3: For an escape entry, bit 7 of the frame byte at index 3 selects the length: 16 bytes when it is 1 and 8 bytes when it is 0. No descriptor is shown while fewer than 4 bytes are buffered.
- R4: A descriptor is shown only when the whole frame is buffered. While `frm_ready_i` is low, its length, flag and offset stay unchanged.
- R5: An illegal leading byte (class code 0, 6 or 7) gives a descriptor with `frm_illegal_o`=1 and length 1. The framer then resumes at the next byte without stalling.
- R6: Each descriptor's offset equals the sum of the lengths of all earlier accepted descriptors since reset.
- R7: With `scalar_mode_i`=1, the table is bypassed. A leading byte whose low nibble is 0xE or 0xF gives 3 bytes, any other gives 2 bytes, and no frame is illegal.
- R8: A table write (`tbl_we_i`, `tbl_addr_i`, `tbl_cls_i` with codes 0 illegal, 1 two, 2 three, 3 eight, 4 sixteen, 5 escape) takes effect only when the window is empty. A write issued while any byte is buffered is dropped.
- R9: `in_ready_o` falls when 32 bytes are buffered. No byte is lost or reordered under output backpressure.
- R10: A descriptor without the illegal flag always has a length of 2, 3, 8 or 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scalar_mode_i | input | 1 | Selects the fixed scalar length rule |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Window can take a byte |
| in_data_i | input | 8 | Input byte |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | 8 | Table entry index (leading byte value) |
| tbl_cls_i | input | 3 | Class code to store |
| frm_valid_o | output | 1 | Frame descriptor valid |
| frm_ready_i | input | 1 | Frame descriptor taken |
| frm_offset_o | output | 32 | Stream offset of the frame's first byte |
| frm_len_o | output | 5 | Frame length in bytes |
| frm_illegal_o | output | 1 | Leading byte has no legal length |

## Verification
Two events can land in the same cycle: a table write while the window is empty, and the arrival of the byte that the written entry will classify. The bench drives the write strobe and that first byte on the same clock edge. It expects the new class to govern the frame, because the lookup happens only after the byte has entered the window. A companion case issues a write while a byte sits in the window under backpressure. The bench then checks that the pending and later frames still follow the old entry.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int BYTE_W  = 8;
  localparam int MAX_LEN = 16;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int CLS_W   = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_ILL = 3'd0,
    CLS_2   = 3'd1,
    CLS_3   = 3'd2,
    CLS_8   = 3'd3,
    CLS_16  = 3'd4,
    CLS_ESC = 3'd5
  } len_cls_e;

  // advance steps: four real sizes plus one-byte resync
  typedef enum logic [2:0] {
    ADV_RESYNC,
    ADV_2,
    ADV_3,
    ADV_8,
    ADV_16
  } adv_e;

  function automatic len_cls_e ref_class(input logic [BYTE_W-1:0] b);
    if (b <= 8'h5F)      return CLS_2;
    else if (b <= 8'hDF) return CLS_3;
    else if (b <= 8'hE7) return CLS_8;
    else if (b == 8'hF8) return CLS_ESC;
    else if (b <= 8'hFD) return CLS_16;
    else                 return CLS_ILL;
  endfunction

  function automatic logic [LEN_W-1:0] adv_len(input adv_e a);
    case (a)
      ADV_2:   return LEN_W'(2);
      ADV_3:   return LEN_W'(3);
      ADV_8:   return LEN_W'(8);
      ADV_16:  return LEN_W'(16);
      default: return LEN_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/len_table.sv
module len_table
  import framer_pkg::*;
#(
  parameter int ADDR_W = BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [CLS_W-1:0]  wcls_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output len_cls_e          cls_o
);
  localparam int ENTRIES = 1 << ADDR_W;

  logic [CLS_W-1:0] mem_q [ENTRIES];
  logic [CLS_W-1:0] rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= CLS_W'(ref_class(BYTE_W'(i)));
    end else if (we_i && idle_i) begin
      mem_q[waddr_i] <= wcls_i;
    end
  end

  assign rd    = mem_q[raddr_i];
  // unused codes fold to illegal
  assign cls_o = (rd > CLS_W'(CLS_ESC)) ? CLS_ILL : len_cls_e'(rd);
endmodule

// File: rtl/len_resolver.sv
module len_resolver
  import framer_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              scalar_i,
  input  len_cls_e          cls_i,
  input  logic [BYTE_W-1:0] b0_i,
  input  logic [BYTE_W-1:0] b3_i,
  input  logic [CNT_W-1:0]  avail_i,
  output logic [LEN_W-1:0]  len_o,
  output logic              illegal_o,
  output logic              ready_o
);
  adv_e adv;

  always_comb begin
    if (scalar_i) begin
      adv = (b0_i[3:0] >= 4'hE) ? ADV_3 : ADV_2;
    end else begin
      case (cls_i)
        CLS_2:   adv = ADV_2;
        CLS_3:   adv = ADV_3;
        CLS_8:   adv = ADV_8;
        CLS_16:  adv = ADV_16;
        CLS_ESC: adv = b3_i[7] ? ADV_16 : ADV_8;
        default: adv = ADV_RESYNC;
      endcase
    end
  end

  assign len_o     = adv_len(adv);
  assign illegal_o = (adv == ADV_RESYNC);
  // escape sizes are >= 8, so byte 3 is present whenever ready
  assign ready_o   = (avail_i >= CNT_W'(len_o));
endmodule

// File: rtl/byte_window.sv
module byte_window
  import framer_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [BYTE_W-1:0] din_i,
  input  logic              pop_i,
  input  logic [LEN_W-1:0]  pop_len_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o,
  output logic [BYTE_W-1:0] b0_o,
  output logic [BYTE_W-1:0] b3_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [BYTE_W-1:0] buf_q [DEPTH];
  logic [BYTE_W-1:0] buf_d [DEPTH];
  logic [CNT_W-1:0]  count_q, count_d, pop_amt, wr_ptr;

  assign pop_amt = pop_i ? CNT_W'(pop_len_i) : '0;
  assign wr_ptr  = count_q - pop_amt;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic [CNT_W:0] src;
      src = (CNT_W+1)'(i) + {1'b0, pop_amt};
      buf_d[i] = (src < (CNT_W+1)'(DEPTH)) ? buf_q[src[IDX_W-1:0]] : '0;
    end
    if (push_i) buf_d[wr_ptr[IDX_W-1:0]] = din_i;
    count_d = wr_ptr + (push_i ? CNT_W'(1) : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
    end else begin
      count_q <= count_d;
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= buf_d[i];
    end
  end

  assign count_o = count_q;
  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign b0_o    = buf_q[0];
  assign b3_o    = buf_q[3];

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (count_q < CNT_W'(DEPTH)));
  assert_pop_whole_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (CNT_W'(pop_len_i) <= count_q));
  assert_count_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/bundle_framer.sv
module bundle_framer
  import framer_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int OFFS_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scalar_mode_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [7:0]        in_data_i,
  input  logic              tbl_we_i,
  input  logic [7:0]        tbl_addr_i,
  input  logic [2:0]        tbl_cls_i,
  output logic              frm_valid_o,
  input  logic              frm_ready_i,
  output logic [OFFS_W-1:0] frm_offset_o,
  output logic [4:0]        frm_len_o,
  output logic              frm_illegal_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]  count;
  logic              full, push, pop, ready;
  logic [BYTE_W-1:0] b0, b3;
  logic [LEN_W-1:0]  len;
  len_cls_e          cls;
  logic [OFFS_W-1:0] offset_q;

  assign in_ready_o = !full;
  assign push       = in_valid_i && !full;
  assign pop        = frm_valid_o && frm_ready_i;

  byte_window #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_window (
    .clk_i, .rst_ni,
    .push_i(push), .din_i(in_data_i),
    .pop_i(pop), .pop_len_i(len),
    .count_o(count), .full_o(full), .b0_o(b0), .b3_o(b3)
  );

  len_table #(.ADDR_W(BYTE_W)) u_table (
    .clk_i, .rst_ni,
    .idle_i(count == '0),
    .we_i(tbl_we_i), .waddr_i(tbl_addr_i), .wcls_i(tbl_cls_i),
    .raddr_i(b0), .cls_o(cls)
  );

  len_resolver #(.CNT_W(CNT_W)) u_resolve (
    .scalar_i(scalar_mode_i), .cls_i(cls),
    .b0_i(b0), .b3_i(b3), .avail_i(count),
    .len_o(len), .illegal_o(frm_illegal_o), .ready_o(ready)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  offset_q <= '0;
    else if (pop) offset_q <= offset_q + OFFS_W'(len);
  end

  assign frm_valid_o  = ready;
  assign frm_offset_o = offset_q;
  assign frm_len_o    = len;

  assert_legal_size_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_o && !frm_illegal_o) |->
      (frm_len_o == 5'd2 || frm_len_o == 5'd3 || frm_len_o == 5'd8 || frm_len_o == 5'd16));
  assert_resync_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_o && frm_illegal_o) |-> (frm_len_o == 5'd1));
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_o && !frm_ready_i) |=>
      ((frm_valid_o && $stable(frm_len_o) && $stable(frm_offset_o) && $stable(frm_illegal_o))
       || (scalar_mode_i != $past(scalar_mode_i))));
  assert_offset_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_o && frm_ready_i) |=>
      (frm_offset_o == $past(frm_offset_o) + OFFS_W'($past(frm_len_o))));
  assert_scalar_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_o && scalar_mode_i) |-> !frm_illegal_o);
endmodule

// File: tb/bundle_framer_test.sv
module bundle_framer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        scalar_mode = 0, in_valid = 0, in_ready;
  logic [7:0]  in_data = 0;
  logic        tbl_we = 0;
  logic [7:0]  tbl_addr = 0;
  logic [2:0]  tbl_cls = 0;
  logic        frm_valid, frm_ready = 1, frm_illegal;
  logic [31:0] frm_offset;
  logic [4:0]  frm_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  bundle_framer uut (
    .clk_i(clk), .rst_ni(rst_n), .scalar_mode_i(scalar_mode),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr), .tbl_cls_i(tbl_cls),
    .frm_valid_o(frm_valid), .frm_ready_i(frm_ready),
    .frm_offset_o(frm_offset), .frm_len_o(frm_len), .frm_illegal_o(frm_illegal)
  );

  int checks = 0, fails = 0;
  logic [7:0] stim [0:255];
  int n_stim = 0, n_lim = 0, ptr = 0;
  bit drv_en = 1, fire = 0;
  int fr_len [0:63], fr_off [0:63], fr_ill [0:63], nfr = 0;
  int ex_len [0:63], ex_ill [0:63], nexp = 0;
  int exp_off = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // stimulus driver: handshake decided at 3/4 period
  initial begin
    forever begin
      @(negedge clk);
      if (fire) ptr++;
      if (drv_en) begin
        if (ptr < n_lim) begin in_valid = 1; in_data = stim[ptr]; end
        else in_valid = 0;
      end
      #(CLK_PERIOD/4);
      fire = drv_en && in_valid && in_ready;
    end
  end

  // frame monitor
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (frm_valid && frm_ready && nfr < 64) begin
        fr_len[nfr] = frm_len; fr_off[nfr] = frm_offset; fr_ill[nfr] = frm_illegal;
        nfr++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  task automatic start_test();
    n_stim = 0; nexp = 0; nfr = 0; ptr = 0; n_lim = 0;
  endtask

  task automatic add_frame(input logic [7:0] first, input int len, input int ill,
                           input logic [7:0] b3 = 8'h00);
    stim[n_stim++] = first;
    for (int i = 1; i < len; i++) stim[n_stim++] = (i == 3) ? b3 : 8'h00;
    ex_len[nexp] = ill ? 1 : len; ex_ill[nexp] = ill; nexp++;
  endtask

  task automatic wait_frames(input int n);
    for (int t = 0; t < 3000 && nfr < n; t++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_frames(input string req);
    chk(nfr == nexp, req, "frame count", nfr, nexp);
    for (int k = 0; k < nexp && k < nfr; k++) begin
      chk(fr_len[k] == ex_len[k], req, $sformatf("len[%0d]", k), fr_len[k], ex_len[k]);
      chk(fr_ill[k] == ex_ill[k], req, $sformatf("illegal[%0d]", k), fr_ill[k], ex_ill[k]);
      chk(fr_off[k] == exp_off, "R6", $sformatf("offset[%0d]", k), fr_off[k], exp_off);
      exp_off += ex_len[k];
    end
  endtask

  task automatic run_all(input string req);
    n_lim = n_stim;
    wait_frames(nexp);
    check_frames(req);
  endtask

  task automatic tbl_write(input logic [7:0] a, input logic [2:0] c);
    @(negedge clk);
    tbl_we = 1; tbl_addr = a; tbl_cls = c;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic test_reset();
    chk(frm_valid == 0, "R1", "frm_valid", frm_valid, 0);
    chk(in_ready == 1, "R1", "in_ready", in_ready, 1);
    chk(frm_offset == 0, "R1", "offset", frm_offset, 0);
  endtask

  task automatic test_table_pop();
    start_test();
    add_frame(8'h00, 2, 0); add_frame(8'h5F, 2, 0);
    add_frame(8'h60, 3, 0); add_frame(8'hDF, 3, 0);
    add_frame(8'hE0, 8, 0); add_frame(8'hE7, 8, 0);
    add_frame(8'hE8, 16, 0); add_frame(8'hFD, 16, 0);
    add_frame(8'h10, 2, 0);
    run_all("R2");
  endtask

  task automatic test_escape();
    start_test();
    add_frame(8'hF8, 16, 0, 8'h80);
    add_frame(8'hF8, 8, 0, 8'h7F);
    run_all("R3");
    // partial arrival
    start_test();
    add_frame(8'hF8, 16, 0, 8'h80);
    n_lim = 3; repeat (8) @(negedge clk);
    chk(frm_valid == 0, "R3", "valid with 3 bytes", frm_valid, 0);
    n_lim = 8; repeat (12) @(negedge clk);
    chk(frm_valid == 0, "R4", "valid with 8 of 16 bytes", frm_valid, 0);
    run_all("R3");
  endtask

  task automatic test_illegal();
    start_test();
    add_frame(8'hFE, 1, 1);
    add_frame(8'h20, 2, 0);
    add_frame(8'hFF, 1, 1);
    add_frame(8'h61, 3, 0);
    run_all("R5");
  endtask

  task automatic test_scalar();
    @(negedge clk); scalar_mode = 1;
    start_test();
    add_frame(8'h0E, 3, 0); add_frame(8'h1F, 3, 0);
    add_frame(8'h25, 2, 0); add_frame(8'hFE, 3, 0);
    add_frame(8'hE0, 2, 0);
    run_all("R7");
    @(negedge clk); scalar_mode = 0;
  endtask

  task automatic test_write_idle();
    tbl_write(8'h10, 3'd3);
    start_test();
    add_frame(8'h10, 8, 0);
    run_all("R8");
    tbl_write(8'h10, 3'd1);
    start_test();
    add_frame(8'h10, 2, 0);
    run_all("R8");
  endtask

  task automatic test_write_busy();
    @(negedge clk); frm_ready = 0;
    start_test();
    add_frame(8'h20, 2, 0);
    n_lim = n_stim; repeat (5) @(negedge clk);
    tbl_write(8'h20, 3'd4);
    repeat (2) @(negedge clk);
    chk(frm_len == 2, "R8", "pending len after busy write", frm_len, 2);
    frm_ready = 1;
    wait_frames(1);
    check_frames("R8");
    start_test();
    add_frame(8'h20, 2, 0);
    run_all("R8");
  endtask

  task automatic test_backpressure();
    @(negedge clk); frm_ready = 0;
    start_test();
    for (int i = 0; i < 20; i++) add_frame(8'h00, 2, 0);
    n_lim = n_stim;
    repeat (60) @(negedge clk);
    chk(in_ready == 0, "R9", "in_ready when full", in_ready, 0);
    chk(frm_valid == 1, "R4", "valid held", frm_valid, 1);
    chk(frm_offset == exp_off, "R4", "offset held", frm_offset, exp_off);
    frm_ready = 1;
    wait_frames(20);
    check_frames("R9");
  endtask

  task automatic test_same_cycle();
    start_test();
    drv_en = 0;
    @(negedge clk);
    in_valid = 1; in_data = 8'h30;
    tbl_we = 1; tbl_addr = 8'h30; tbl_cls = 3'd4;
    @(negedge clk);
    tbl_we = 0;
    for (int i = 1; i < 16; i++) begin
      in_data = 8'h00;
      @(negedge clk);
    end
    in_valid = 0;
    ex_len[0] = 16; ex_ill[0] = 0; nexp = 1;
    wait_frames(1);
    check_frames("R8");
    drv_en = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    test_reset();
    test_table_pop();
    test_escape();
    test_illegal();
    test_scalar();
    test_write_idle();
    test_write_busy();
    test_backpressure();
    test_same_cycle();
    summary();
  end
endmodule